// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

This block steers every incoming interrupt request to exactly one CPU out of a parameterized set. A routing table holds, for each interrupt line, a home CPU and a flag that says whether the route is pinned or may move. Each CPU also has a small priority level that software raises while the CPU is busy or about to go offline. A pinned route always lands on its home CPU. A movable route goes to the least loaded CPU. The search for that CPU starts at the home CPU and wraps upward by index, so the home CPU wins any tie.

At reset the table loads in one of two ways, chosen by a strap input. With redirection on, every line is movable and homed on CPU 0. With redirection off, every line is pinned, and line n is homed on CPU n mod N. After reset, a configuration port rewrites single entries. The destination is given as a CPU bit mask, and only its lowest set bit counts. A readback port shows any entry's flag and home CPU.

Each accepted request produces a one-cycle delivery pulse on the next cycle. The pulse carries both the CPU index and a one-hot CPU vector. The block accepts one request per cycle.

Top module: `irq_lp_router`

## Requirements
- R1: A reset with redirEn=1 leaves every entry movable (rdRedir=1) with home CPU 0 (rdMask=0x01), and deliverValid low.
- R2: A reset with redirEn=0 leaves every entry pinned (rdRedir=0), and entry n is homed on CPU n mod NUM_CPU (rdMask=1<<(n mod NUM_CPU)).
- R3: A configuration write with a nonzero cfgMask sets the entry's home CPU to the index of the lowest set bit of cfgMask, and sets its flag to cfgRedir (1 = movable, 0 = pinned). For example, mask 0x28 gives CPU 3.
- R4: A configuration write with cfgMask=0 changes neither the flag nor the home CPU of the entry.
- R5: A pinned entry delivers to its home CPU whatever the priority levels are.
- R6: A movable entry delivers to a CPU holding the numerically lowest 2-bit level. The levels are 00 for idle, 01 for busy and 11 for going offline, compared as unsigned numbers.
- R7: Among CPUs that tie on the lowest level, the first one met wins. The search order is the home CPU, then home+1, and so on, wrapping modulo NUM_CPU.
- R8: deliverValid is high in exactly the cycle after an irqValid cycle, with deliverCpu holding the chosen index and deliverOneHot equal to 1<<deliverCpu. Otherwise deliverValid is low and deliverOneHot is zero.
- R9: A request accepted in the same cycle as a table write or a level write is routed with the table and levels as they stood before that cycle.
- R10: After reset every CPU level is 00, so a movable request goes to its home CPU until levels are written. Level writes use xtpWe bit c and xtpLevel bits [2c+1:2c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset, loads the table |
| redirEn | input | 1 | Strap: 1 loads movable entries on CPU 0, 0 loads pinned round-robin entries |
| cfgWe | input | 1 | Table entry write strobe |
| cfgIrq | input | 6 | Entry to write |
| cfgMask | input | 8 | Destination CPU mask, lowest set bit used |
| cfgRedir | input | 1 | 1 movable, 0 pinned |
| xtpWe | input | 8 | Per-CPU level write enables |
| xtpLevel | input | 16 | Packed levels, 2 bits per CPU |
| irqValid | input | 1 | Request strobe |
| irqNum | input | 6 | Requesting interrupt line |
| rdIrq | input | 6 | Readback entry select |
| rdRedir | output | 1 | Flag of the selected entry |
| rdMask | output | 8 | Home CPU of the selected entry, one-hot |
| deliverValid | output | 1 | One-cycle delivery pulse |
| deliverCpu | output | 3 | Chosen CPU index |
| deliverOneHot | output | 8 | Chosen CPU, one-hot |

## Verification
A request can arrive in the same cycle as a table write to its own entry, or in the same cycle as a level write to a CPU that would change the winner. Directed cases do both at once. One fires a movable line while its entry is rewritten to a pinned one and the current winner's competitor drops to idle. The bench expects the old choice, then the new one on the following request. The random phase mixes requests with table and level writes in the same cycles, including zero-mask writes. Each result is judged against a bench model that takes its routing decision before it applies that cycle's writes.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  typedef struct packed {
    logic initLoad;
    logic tableWr;
    logic route;
  } rtStrb_t;
endpackage

// File: rtl/irq_rt_ctrl.sv
module irq_rt_ctrl
  import irq_rt_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_IRQ = 64,
  localparam int IRQ_W = $clog2(NUM_IRQ)
) (
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [IRQ_W-1:0]   cfgIrq,
  input  logic [NUM_CPU-1:0] cfgMask,
  input  logic               irqValid,
  input  logic [IRQ_W-1:0]   irqNum,
  output rtStrb_t            strb
);
  logic cfgInRange;
  logic irqInRange;

  assign cfgInRange = 32'(cfgIrq) < NUM_IRQ;
  assign irqInRange = 32'(irqNum) < NUM_IRQ;

  always_comb begin
    strb.initLoad = !rstN;
    strb.tableWr  = rstN && cfgWe && (|cfgMask) && cfgInRange;
    strb.route    = rstN && irqValid && irqInRange;
  end
endmodule

// File: rtl/irq_rt_data.sv
module irq_rt_data
  import irq_rt_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_IRQ = 64,
  parameter int XTP_W   = 2,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
  input  logic                     clk,
  input  rtStrb_t                  strb,
  input  logic                     redirEn,
  input  logic [IRQ_W-1:0]         cfgIrq,
  input  logic [NUM_CPU-1:0]       cfgMask,
  input  logic                     cfgRedir,
  input  logic [NUM_CPU-1:0]       xtpWe,
  input  logic [NUM_CPU*XTP_W-1:0] xtpLevel,
  input  logic [IRQ_W-1:0]         irqNum,
  input  logic [IRQ_W-1:0]         rdIrq,
  output logic                     rdRedir,
  output logic [NUM_CPU-1:0]       rdMask,
  output logic                     deliverValid,
  output logic [CPU_W-1:0]         deliverCpu,
  output logic [NUM_CPU-1:0]       deliverOneHot
);
  logic [CPU_W-1:0]   homeTbl [NUM_IRQ];
  logic [NUM_IRQ-1:0] redirTbl;
  logic [XTP_W-1:0]   xtp [NUM_CPU];
  logic [CPU_W-1:0]   homeIdx, winIdx, pickIdx;
  logic               selRedir;
  logic               validQ;
  logic [CPU_W-1:0]   cpuQ;

  function automatic logic [CPU_W-1:0] lowBit(input logic [NUM_CPU-1:0] m);
    logic [CPU_W-1:0] r;
    r = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--)
      if (m[i]) r = CPU_W'(i);
    return r;
  endfunction

  // routing table: strap-selected load, then single-entry writes
  always_ff @(posedge clk) begin
    if (strb.initLoad) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        homeTbl[i]  <= redirEn ? '0 : CPU_W'(i % NUM_CPU);
        redirTbl[i] <= redirEn;
      end
    end else if (strb.tableWr) begin
      homeTbl[cfgIrq]  <= lowBit(cfgMask);
      redirTbl[cfgIrq] <= cfgRedir;
    end
  end

  // per-CPU priority levels
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_xtp
    always_ff @(posedge clk) begin
      if (strb.initLoad)  xtp[c] <= '0;
      else if (xtpWe[c])  xtp[c] <= xtpLevel[c*XTP_W +: XTP_W];
    end
  end

  assign homeIdx  = homeTbl[irqNum];
  assign selRedir = redirTbl[irqNum];

  // cyclic least-level search from the home CPU; strict compare keeps first hit
  always_comb begin
    logic [CPU_W-1:0] cand;
    winIdx = homeIdx;
    for (int k = 1; k < NUM_CPU; k++) begin
      cand = CPU_W'((int'(homeIdx) + k) % NUM_CPU);
      if (xtp[cand] < xtp[winIdx]) winIdx = cand;
    end
  end

  assign pickIdx = selRedir ? winIdx : homeIdx;

  always_ff @(posedge clk) begin
    if (strb.initLoad) begin
      validQ <= 1'b0;
      cpuQ   <= '0;
    end else begin
      validQ <= strb.route;
      if (strb.route) cpuQ <= pickIdx;
    end
  end

  assign deliverValid  = validQ;
  assign deliverCpu    = cpuQ;
  assign deliverOneHot = validQ ? (NUM_CPU'(1) << cpuQ) : '0;
  assign rdRedir       = redirTbl[rdIrq];
  assign rdMask        = NUM_CPU'(1) << homeTbl[rdIrq];

  assert_fixed_target_R5: assert property (@(posedge clk) disable iff (strb.initLoad)
    (strb.route && !selRedir) |=> (deliverCpu == $past(homeIdx)));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_lowest_level_R6: assert property (@(posedge clk) disable iff (strb.initLoad)
      (strb.route && selRedir) |-> (xtp[winIdx] <= xtp[c]));
  end
endmodule

// File: rtl/irq_lp_router.sv
module irq_lp_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_IRQ = 64,
  parameter int XTP_W   = 2,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     redirEn,
  input  logic                     cfgWe,
  input  logic [IRQ_W-1:0]         cfgIrq,
  input  logic [NUM_CPU-1:0]       cfgMask,
  input  logic                     cfgRedir,
  input  logic [NUM_CPU-1:0]       xtpWe,
  input  logic [NUM_CPU*XTP_W-1:0] xtpLevel,
  input  logic                     irqValid,
  input  logic [IRQ_W-1:0]         irqNum,
  input  logic [IRQ_W-1:0]         rdIrq,
  output logic                     rdRedir,
  output logic [NUM_CPU-1:0]       rdMask,
  output logic                     deliverValid,
  output logic [CPU_W-1:0]         deliverCpu,
  output logic [NUM_CPU-1:0]       deliverOneHot
);
  rtStrb_t strb;

  irq_rt_ctrl #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_ctrl (
    .rstN(rstN), .cfgWe(cfgWe), .cfgIrq(cfgIrq), .cfgMask(cfgMask),
    .irqValid(irqValid), .irqNum(irqNum), .strb(strb)
  );

  irq_rt_data #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .XTP_W(XTP_W)) u_data (
    .clk(clk), .strb(strb), .redirEn(redirEn), .cfgIrq(cfgIrq),
    .cfgMask(cfgMask), .cfgRedir(cfgRedir), .xtpWe(xtpWe),
    .xtpLevel(xtpLevel), .irqNum(irqNum), .rdIrq(rdIrq),
    .rdRedir(rdRedir), .rdMask(rdMask), .deliverValid(deliverValid),
    .deliverCpu(deliverCpu), .deliverOneHot(deliverOneHot)
  );

  assert_pulse_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |=> deliverValid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |=> !deliverValid);

  assert_zero_mask_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgMask == '0 && rdIrq == cfgIrq) |=>
      (!$stable(rdIrq) || (rdMask == $past(rdMask) && rdRedir == $past(rdRedir))));
endmodule

// File: tb/sim_irq_lp_router.sv
module sim_irq_lp_router;
  localparam int NC = 8;
  localparam int NI = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, redirEn, cfgWe, cfgRedir, irqValid, rdRedir, deliverValid;
  logic [5:0]  cfgIrq, irqNum, rdIrq;
  logic [7:0]  cfgMask, xtpWe, rdMask, deliverOneHot;
  logic [15:0] xtpLevel;
  logic [2:0]  deliverCpu;

  irq_lp_router u0 (
    .clk(clk), .rstN(rstN), .redirEn(redirEn), .cfgWe(cfgWe), .cfgIrq(cfgIrq),
    .cfgMask(cfgMask), .cfgRedir(cfgRedir), .xtpWe(xtpWe), .xtpLevel(xtpLevel),
    .irqValid(irqValid), .irqNum(irqNum), .rdIrq(rdIrq), .rdRedir(rdRedir),
    .rdMask(rdMask), .deliverValid(deliverValid), .deliverCpu(deliverCpu),
    .deliverOneHot(deliverOneHot)
  );

  int total = 0;
  int bad = 0;
  int mTgt [NI];
  bit mRed [NI];
  int mXtp [NC];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowIdx(logic [7:0] m);
    for (int i = 0; i < NC; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int expRoute(int irq);
    int best = mTgt[irq];
    if (!mRed[irq]) return best;
    for (int k = 1; k < NC; k++) begin
      int idx = (mTgt[irq] + k) % NC;
      if (mXtp[idx] < mXtp[best]) best = idx;
    end
    return best;
  endfunction

  task automatic idle();
    cfgWe = 0; cfgIrq = 0; cfgMask = 0; cfgRedir = 0;
    xtpWe = 0; xtpLevel = 0; irqValid = 0; irqNum = 0;
  endtask

  task automatic doReset(bit re);
    redirEn = re; rstN = 0; idle(); rdIrq = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    for (int i = 0; i < NI; i++) begin
      mTgt[i] = re ? 0 : i % NC;
      mRed[i] = re;
    end
    for (int c = 0; c < NC; c++) mXtp[c] = 0;
  endtask

  task automatic op(bit iv, int irq, bit cw, int ci, logic [7:0] m, bit cr,
                    logic [7:0] we, logic [15:0] lv, string req);
    int exp;
    irqValid = iv; irqNum = 6'(irq); cfgWe = cw; cfgIrq = 6'(ci);
    cfgMask = m; cfgRedir = cr; xtpWe = we; xtpLevel = lv;
    exp = iv ? expRoute(irq) : 0;
    if (cw && m != 0) begin mTgt[ci] = lowIdx(m); mRed[ci] = cr; end
    for (int c = 0; c < NC; c++) if (we[c]) mXtp[c] = int'(lv[2*c +: 2]);
    @(posedge clk);
    #1 idle();
    chk(deliverValid == iv, {"R8 pulse ", req}, int'(deliverValid), int'(iv));
    if (iv)
      chk(int'(deliverCpu) == exp && deliverOneHot == (8'h1 << exp), req,
          int'(deliverCpu), exp);
    else
      chk(deliverOneHot == 0, "R8 idle onehot", int'(deliverOneHot), 0);
  endtask

  task automatic rdChk(int i, string req);
    rdIrq = 6'(i);
    #1;
    chk(rdRedir == mRed[i] && rdMask == (8'h1 << mTgt[i]), req,
        {23'b0, rdRedir, rdMask}, (int'(mRed[i]) << 8) | (1 << mTgt[i]));
  endtask

  task automatic realign();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] lvls [3];
    lvls[0] = 2'b00; lvls[1] = 2'b01; lvls[2] = 2'b11;
    void'($urandom(32'd4711));

    // R2: pinned round-robin load
    doReset(0);
    chk(deliverValid == 0, "R2 reset no pulse", int'(deliverValid), 0);
    for (int i = 0; i < NI; i++) rdChk(i, "R2 init entry");
    realign();
    op(1, 13, 0, 0, 0, 0, 8'hFF, 16'hFFF3, "R5 pinned 13");
    op(1, 6, 0, 0, 0, 0, 0, 0, "R5 pinned 6");

    // R1 / R10: movable load, all levels idle
    doReset(1);
    chk(deliverValid == 0 && deliverOneHot == 0, "R1 reset no pulse",
        int'(deliverValid), 0);
    for (int i = 0; i < NI; i++) rdChk(i, "R1 init entry");
    realign();
    op(1, 5, 0, 0, 0, 0, 0, 0, "R10 idle levels home 0");
    op(0, 0, 1, 4, 8'h20, 1, 0, 0, "R3 set entry 4");
    op(1, 4, 0, 0, 0, 0, 0, 0, "R10 idle tie home 5");
    chk(mTgt[4] == 5, "R10 model", mTgt[4], 5);

    // R3 / R4: mask decode and zero-mask write
    op(0, 0, 1, 7, 8'h28, 0, 0, 0, "R3 write");
    rdChk(7, "R3 lowest bit 0x28");
    realign();
    op(0, 0, 1, 7, 8'h00, 1, 0, 0, "R4 write");
    rdChk(7, "R4 zero mask ignored");
    realign();

    // R5: pinned ignores levels
    op(0, 0, 1, 11, 8'h40, 0, 8'hFF, 16'hFFF3, "R5 setup");
    op(1, 11, 0, 0, 0, 0, 0, 0, "R5 pinned despite levels");

    // R6 / R7: lowest level, tie order with wrap
    op(0, 0, 1, 9, 8'h20, 1, 8'hFF, 16'hDFDF, "R7 setup");
    op(1, 9, 0, 0, 0, 0, 0, 0, "R7 tie from home 5 gives 6");
    op(0, 0, 1, 9, 8'h80, 1, 0, 0, "R7 home 7");
    op(1, 9, 0, 0, 0, 0, 0, 0, "R7 wrap gives 2");
    op(0, 0, 1, 9, 8'h20, 1, 8'hFF, 16'hF7FF, "R6 setup");
    op(1, 9, 0, 0, 0, 0, 0, 0, "R6 single low cpu");

    // R9: same-cycle writes use old state
    op(0, 0, 0, 0, 0, 0, 8'hFF, 16'hDFDF, "R9 setup");
    op(1, 9, 1, 9, 8'h01, 0, 8'h20, 16'h0000, "R9 fire during writes");
    op(1, 9, 0, 0, 0, 0, 0, 0, "R9 new state after");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] lv;
      logic [7:0]  m;
      for (int c = 0; c < NC; c++) lv[2*c +: 2] = lvls[$urandom % 3];
      m = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
      op($urandom % 2 == 1, int'($urandom % NI), $urandom % 3 == 0,
         int'($urandom % NI), m, $urandom % 2 == 1,
         ($urandom % 3 == 0) ? 8'($urandom) : 8'h00, lv,
         "R5 R6 R7 R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule